// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter with Cascade Pass-Through

This block decides which of four DMA request channels gets the bus. Each channel has a hardware request pin and a software request bit that the CPU can program. When any unmasked channel requests service, the arbiter raises a hold request toward the bus master. Once the master returns hold acknowledge, the arbiter asserts the acknowledge of the highest-priority requester. Two priority schemes are available. In fixed priority, channel 0 is the highest. In rotating priority, the channel that was just served drops to the lowest position.

Any channel can be placed in cascade mode. A cascade channel's request pin is wired to the hold-request output of a downstream arbiter, and its acknowledge drives that arbiter's hold-acknowledge input. Such a channel only competes for priority. It never raises the transfer-enable output and never reacts to software requests. Because a downstream arbiter can itself hold a cascade channel, trees of two or three levels can be built.

A command field sets the polarity of the request pins and the acknowledge pins, so that an upstream cascade channel can see active-low requests and drive active-high acknowledges. Registers are loaded through a plain write port.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, hold_req is low and every dack_out bit is at its inactive level. The reset command is 0, which makes requests active-high and acknowledges active-low, so dack_out is all ones. All mask bits reset to 1, so no request raises hold_req until the mask is written.
- R2: An unmasked active request raises hold_req on the first rising edge at which it is seen. No acknowledge is asserted while hold_ack is low.
- R3: When hold_ack is high in the waiting phase, exactly one acknowledge becomes active on that edge, for the winning channel.
- R4: With command bit 0 clear (fixed priority), the lowest-numbered requesting channel wins.
- R5: With command bit 0 set (rotating priority), the search starts at the channel after the last one served, so the served channel becomes the lowest priority. After reset the search starts at channel 0.
- R6: A grant is held, with no preemption and regardless of hold_ack, for as long as the granted channel's effective request stays active. One edge after that request drops, hold_req and the acknowledge are released.
- R7: Register address 1, bits [3:0], is the mask (1 = masked). A masked channel is never granted. Masking a granted channel ends its grant on the second edge after the write.
- R8: Register address 2, bits [3:0], holds the software request bits. A set bit requests service for a non-cascade channel exactly as its pin would.
- R9: Register address 3, bits [3:0], selects cascade mode per channel. A cascade channel ignores its software request bit. While it is granted, xfer_en stays low. xfer_en is high only while a non-cascade channel is granted.
- R10: Register address 0 is the command. Bit 1 = 1 makes the request pins active-low. Bit 2 = 1 makes the acknowledges active-high.
- R11: At most one acknowledge is active at any time, and hold_req is high whenever one is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 command, 1 mask, 2 software request, 3 cascade |
| wr_data | input | 4 | Write data |
| dreq_in | input | 4 | Per-channel hardware request, or downstream hold request in cascade mode |
| hold_ack | input | 1 | Hold acknowledge from the bus master |
| hold_req | output | 1 | Hold request to the bus master |
| dack_out | output | 4 | Per-channel acknowledge, polarity set by the command |
| xfer_en | output | 1 | High while a non-cascade channel holds the grant |

## Verification
The bench targets four failure modes.

- **Software request on a cascade channel.** It sets a software request on a cascade channel and checks that no hold request follows. A design that failed to gate the bit would start a grant that no downstream arbiter ever asked for and hang the tree.
- **Rotating priority.** It keeps all four channels requesting while it releases them one at a time. A broken rotating pointer would hand the bus back to channel 0 every time.
- **Preemption.** It raises a higher-priority request during a live grant. A design that re-arbitrated mid-grant would move the acknowledge.
- **Masking and polarity.** It masks a granted channel and drives inverted polarities. A design that missed either would keep a dead grant or decode the idle pin levels as requests.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_GRANT = 2'd2
  } arb_state_e;

  typedef struct packed {
    logic ack_high;
    logic req_low;
    logic rotate;
  } arb_cmd_t;

  localparam logic [1:0] REG_CMD  = 2'd0;
  localparam logic [1:0] REG_MASK = 2'd1;
  localparam logic [1:0] REG_SWRQ = 2'd2;
  localparam logic [1:0] REG_CASC = 2'd3;

endpackage

// File: rtl/dma_arb_regs.sv
module dma_arb_regs
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [NCH-1:0] wr_data,
  output arb_cmd_t       cmd_q,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] swrq_q,
  output logic [NCH-1:0] casc_q
);

  arb_cmd_t       cmd_d;
  logic [NCH-1:0] mask_d, swrq_d, casc_d;
  logic           cmd_en, mask_en, swrq_en, casc_en;

  always_comb begin
    cmd_en  = wr_en && (wr_addr == REG_CMD);
    mask_en = wr_en && (wr_addr == REG_MASK);
    swrq_en = wr_en && (wr_addr == REG_SWRQ);
    casc_en = wr_en && (wr_addr == REG_CASC);
    cmd_d   = '{ack_high: wr_data[2], req_low: wr_data[1], rotate: wr_data[0]};
    mask_d  = wr_data;
    swrq_d  = wr_data;
    casc_d  = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mask_q <= '1;
      swrq_q <= '0;
      casc_q <= '0;
    end else begin
      if (cmd_en)  cmd_q  <= cmd_d;
      if (mask_en) mask_q <= mask_d;
      if (swrq_en) swrq_q <= swrq_d;
      if (casc_en) casc_q <= casc_d;
    end
  end

endmodule

// File: rtl/dma_arb_reqcond.sv
module dma_arb_reqcond #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] dreq_in,
  input  logic           req_low,
  input  logic [NCH-1:0] mask_q,
  input  logic [NCH-1:0] swrq_q,
  input  logic [NCH-1:0] casc_q,
  output logic [NCH-1:0] eff_req
);

  logic [NCH-1:0] pin_req;
  logic [NCH-1:0] sw_ok;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    // polarity decode, then software requests only for non-cascade channels
    assign pin_req[c] = dreq_in[c] ^ req_low;
    assign sw_ok[c]   = swrq_q[c] & ~casc_q[c];
    assign eff_req[c] = (pin_req[c] | sw_ok[c]) & ~mask_q[c];
  end

endmodule

// File: rtl/dma_arb_prio.sv
module dma_arb_prio #(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req,
  input  logic           rotate,
  input  logic [IW-1:0]  last_q,
  output logic           found,
  output logic [IW-1:0]  win
);

  logic [IW-1:0] base;
  logic [IW:0]   pos;
  logic [IW-1:0] idx;

  always_comb begin
    if (!rotate) begin
      base = '0;
    end else if (last_q == IW'(NCH - 1)) begin
      base = '0;
    end else begin
      base = last_q + IW'(1);
    end
  end

  always_comb begin
    found = 1'b0;
    win   = '0;
    pos   = '0;
    idx   = '0;
    for (int i = 0; i < NCH; i++) begin
      pos = {1'b0, base} + (IW+1)'(i);
      if (pos >= (IW+1)'(NCH)) pos = pos - (IW+1)'(NCH);
      idx = pos[IW-1:0];
      if (!found && req[idx]) begin
        found = 1'b1;
        win   = idx;
      end
    end
  end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [NCH-1:0] wr_data,
  input  logic [NCH-1:0] dreq_in,
  input  logic           hold_ack,
  output logic           hold_req,
  output logic [NCH-1:0] dack_out,
  output logic           xfer_en
);

  arb_cmd_t       cmd_q;
  logic [NCH-1:0] mask_q, swrq_q, casc_q;
  logic [NCH-1:0] eff_req;
  logic           any_req, found;
  logic [IW-1:0]  win;

  arb_state_e     state_q, state_d;
  logic [IW-1:0]  gnt_q, gnt_d;
  logic [IW-1:0]  last_q, last_d;
  logic           gnt_en, last_en;
  logic [NCH-1:0] act_vec;

  dma_arb_regs #(.NCH(NCH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cmd_q   (cmd_q),
    .mask_q  (mask_q),
    .swrq_q  (swrq_q),
    .casc_q  (casc_q)
  );

  dma_arb_reqcond #(.NCH(NCH)) u_cond (
    .dreq_in (dreq_in),
    .req_low (cmd_q.req_low),
    .mask_q  (mask_q),
    .swrq_q  (swrq_q),
    .casc_q  (casc_q),
    .eff_req (eff_req)
  );

  dma_arb_prio #(.NCH(NCH)) u_prio (
    .req    (eff_req),
    .rotate (cmd_q.rotate),
    .last_q (last_q),
    .found  (found),
    .win    (win)
  );

  assign any_req = |eff_req;

  // next-state logic
  always_comb begin
    state_d = state_q;
    gnt_d   = gnt_q;
    gnt_en  = 1'b0;
    last_d  = last_q;
    last_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (any_req) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!any_req) begin
          state_d = ST_IDLE;
        end else if (hold_ack && found) begin
          state_d = ST_GRANT;
          gnt_d   = win;
          gnt_en  = 1'b1;
        end
      end
      ST_GRANT: begin
        if (!eff_req[gnt_q]) begin
          state_d = ST_IDLE;
          last_d  = gnt_q;
          last_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
      last_q  <= IW'(NCH - 1);
    end else begin
      state_q <= state_d;
      if (gnt_en)  gnt_q  <= gnt_d;
      if (last_en) last_q <= last_d;
    end
  end

  // outputs
  always_comb begin
    act_vec  = (state_q == ST_GRANT) ? (NCH'(1) << gnt_q) : '0;
    dack_out = cmd_q.ack_high ? act_vec : ~act_vec;
    hold_req = (state_q != ST_IDLE);
    xfer_en  = (state_q == ST_GRANT) && !casc_q[gnt_q];
  end

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hold_req,
  input logic           hold_ack,
  input logic           xfer_en,
  input logic [NCH-1:0] act_vec,
  input logic [NCH-1:0] mask_q
);

  assert_one_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_vec));

  assert_ack_needs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|act_vec) |-> hold_req);

  assert_grant_after_holdack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|act_vec) && !(|$past(act_vec))) |-> $past(hold_ack));

  assert_masked_never_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|act_vec) |-> ((act_vec & $past(mask_q)) == '0));

  assert_no_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|act_vec) && (|$past(act_vec))) |-> (act_vec == $past(act_vec)));

  assert_xfer_only_in_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en |-> (|act_vec));

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hold_req (hold_req),
  .hold_ack (hold_ack),
  .xfer_en  (xfer_en),
  .act_vec  (act_vec),
  .mask_q   (mask_q)
);

// File: tb/dma_req_arbiter_tb_top.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [3:0] wr_data;
  logic [3:0] dreq_in;
  logic       hold_ack;
  logic       hold_req;
  logic [3:0] dack_out;
  logic       xfer_en;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic [2:0] cur_cmd;

  always #5 clk = ~clk;

  dma_req_arbiter dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .dreq_in  (dreq_in),
    .hold_ack (hold_ack),
    .hold_req (hold_req),
    .dack_out (dack_out),
    .xfer_en  (xfer_en)
  );

  typedef struct packed {
    logic [2:0] cmd;
    logic [3:0] casc;
    logic [3:0] sw;
    logic [3:0] mask;
    logic [3:0] dreq;
    logic [3:0] exp_act;
    logic       exp_x;
  } vec_t;

  // cmd bit0 rotate, bit1 active-low requests, bit2 active-high acks
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 4'h0, 4'h0, 4'h0, 4'b0110, 4'b0010, 1'b1},  // R4
    '{3'd0, 4'h0, 4'h0, 4'h0, 4'b1000, 4'b1000, 1'b1},  // R4
    '{3'd0, 4'h0, 4'h0, 4'b0001, 4'b1111, 4'b0010, 1'b1},  // R7
    '{3'd0, 4'h0, 4'b0100, 4'h0, 4'b0000, 4'b0100, 1'b1},  // R8
    '{3'd0, 4'b0100, 4'b0100, 4'h0, 4'b0000, 4'b0000, 1'b0},  // R9 sw ignored
    '{3'd0, 4'b0001, 4'h0, 4'h0, 4'b0101, 4'b0001, 1'b0},  // R9 cascade grant
    '{3'd2, 4'h0, 4'h0, 4'h0, 4'b1110, 4'b0001, 1'b1},  // R10 active-low req
    '{3'd4, 4'h0, 4'h0, 4'h0, 4'b0100, 4'b0100, 1'b1},  // R10 active-high ack
    '{3'd6, 4'h0, 4'h0, 4'h0, 4'b1011, 4'b0100, 1'b1},  // R10 both
    '{3'd0, 4'h0, 4'h0, 4'hF, 4'b1111, 4'b0000, 1'b0}   // R7 all masked
  };

  function automatic logic [3:0] active_acks();
    return cur_cmd[2] ? dack_out : ~dack_out;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 2'd0) cur_cmd = d[2:0];
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    dreq_in = '0; hold_ack = 1'b0; cur_cmd = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check("R1 hold_req", 32'(hold_req), 0);
    check("R1 dack idle", 32'(dack_out), 32'hF);
    dreq_in = 4'hF;
    repeat (2) @(negedge clk);
    check("R1 masked at reset", 32'(hold_req), 0);
    dreq_in = 4'h0;

    // vector table
    for (int v = 0; v < NV; v++) begin
      wr(2'd0, {1'b0, VECS[v].cmd});
      wr(2'd3, VECS[v].casc);
      wr(2'd2, VECS[v].sw);
      dreq_in = VECS[v].dreq;
      hold_ack = 1'b0;
      wr(2'd1, VECS[v].mask);
      @(negedge clk);
      check("R2 hold_req raised", 32'(hold_req), 32'(VECS[v].exp_act != 0));
      check("R2 no ack before hold_ack", 32'(active_acks()), 0);
      hold_ack = 1'b1;
      @(negedge clk);
      check("R3 granted channel", 32'(active_acks()), 32'(VECS[v].exp_act));
      check("R9 xfer_en", 32'(xfer_en), 32'(VECS[v].exp_x));
      wr(2'd1, 4'hF);
      @(negedge clk);
      check("R7 released by mask", 32'(hold_req), 0);
      check("R7 ack released", 32'(active_acks()), 0);
      hold_ack = 1'b0;
      dreq_in = VECS[v].cmd[1] ? 4'hF : 4'h0;
      wr(2'd2, 4'h0);
      wr(2'd3, 4'h0);
    end

    // R6 grant held without preemption, release one edge after drop
    do_reset();
    wr(2'd0, 4'b0100);
    wr(2'd1, 4'h0);
    dreq_in = 4'b0010;
    hold_ack = 1'b1;
    repeat (2) @(negedge clk);
    check("R6 ch1 granted", 32'(dack_out), 32'b0010);
    hold_ack = 1'b0;
    dreq_in = 4'b0011;
    repeat (4) @(negedge clk);
    check("R6 no preemption", 32'(dack_out), 32'b0010);
    check("R6 hold kept", 32'(hold_req), 1);
    dreq_in = 4'b0001;
    @(negedge clk);
    check("R6 hold released", 32'(hold_req), 0);
    check("R6 ack released", 32'(dack_out), 0);
    dreq_in = 4'h0;
    @(negedge clk);

    // R5 rotating priority with all channels requesting
    do_reset();
    wr(2'd0, 4'b0101);
    wr(2'd1, 4'h0);
    dreq_in = 4'hF;
    hold_ack = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 first grant ch0", 32'(dack_out), 32'b0001);
    for (int k = 0; k < 3; k++) begin
      dreq_in = 4'hF & ~(4'b0001 << k);
      @(negedge clk);
      check("R5 release", 32'(hold_req), 0);
      dreq_in = 4'hF;
      repeat (2) @(negedge clk);
      check("R5 rotated grant", 32'(dack_out), 32'(4'b0001 << (k + 1)));
    end
    // back to fixed: next winner is ch0 again (R4)
    wr(2'd0, 4'b0100);
    dreq_in = 4'b0111;
    @(negedge clk);
    dreq_in = 4'hF;
    repeat (2) @(negedge clk);
    check("R4 fixed after rotate", 32'(dack_out), 32'b0001);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule